// File: doc/BRIEF.md
# Staged Forward Memory Copy Engine

This block carries out a byte copy in increasing address order, from a source address to a destination address. Software splits one copy into three commands: a prologue, a main stage and an epilogue. Each command carries the destination, source and count register values, four option bits and the current condition flags. When it finishes, the engine returns the updated register values and a four-bit flag value, so the next stage can pick up where the last one stopped.

Data moves in blocks over one request/response memory port. Each block is a read followed by a write. Two bookkeeping schemes are supported. In scheme A, the prologue moves both addresses to the end of the region and negates the count, which then climbs toward zero. In scheme B, both addresses advance and the count falls. The prologue records the chosen scheme in the carry flag. If a block access returns an error, the engine stops and returns registers that reflect the blocks already copied, together with the failing address and its direction.

Top module: `fwd_copy_engine`

## Requirements
- R1: A command with stage code 2'b11, or with a size field other than 2'b00, is illegal. The engine raises `res_illegal` and returns the destination, source, count and flags unchanged. It issues no memory request.
- R2: In the prologue (stage 2'b00), a count with bit 63 set is replaced by `MAX_COPY` before any copying.
- R3: In a scheme A prologue (`cfg_scheme_b`=0), the flags become 4'b0000, both addresses gain the count, and the count is negated. Each block reads at source+count and writes at destination+count, and the count rises by the block length.
- R4: In a scheme B prologue, the flags become 4'b0010. Each block reads and writes at the current addresses. Both addresses then advance by the block length, and the count falls by it.
- R5: The main stage (2'b01) and the epilogue (2'b10) return the input flags unchanged and ignore `cfg_scheme_b`. Flag bit 1 (carry) set selects scheme B; clear selects scheme A.
- R6: The prologue and the main stage each copy at most `STAGE_QUOTA` bytes. The epilogue copies the whole remaining count.
- R7: Each block is `BLK` bytes, clipped to the bytes left in the stage. Every block is one read request followed by one write request of the same length.
- R8: The destination bytes equal the source bytes, and no byte past the copied range is written.
- R9: An error response ends the command with `res_fault`=1. `res_fault_addr` gives the failing address, and `res_fault_write` is 1 for a write and 0 for a read. The returned registers reflect only the completed blocks.
- R10: Option bit 3 and bit 1 travel with read requests as non-temporal and unprivileged. Bit 2 and bit 0 do the same for write requests.
- R11: `cmd_ready` is low while `busy` is high. `busy` rises on command accept and stays high until the one-cycle `res_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_scheme_b | input | 1 | Scheme chosen at prologue: 0 = A, 1 = B |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_stage | input | 2 | 00 prologue, 01 main, 10 epilogue |
| cmd_size | input | 2 | Element size; only 00 is legal |
| cmd_opts | input | 4 | Non-temporal and unprivileged controls |
| cmd_nzcv | input | 4 | Current condition flags |
| cmd_dst | input | 64 | Destination register value |
| cmd_src | input | 64 | Source register value |
| cmd_cnt | input | 64 | Count register value |
| req_valid | output | 1 | Memory request |
| req_ready | input | 1 | Memory accepts request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 64 | Byte address |
| req_len | output | $clog2(BLK+1) | Bytes in block |
| req_wdata | output | 8*BLK | Write data, byte i in lane i |
| req_nontemporal | output | 1 | Non-temporal attribute |
| req_unpriv | output | 1 | Unprivileged attribute |
| rsp_valid | input | 1 | Memory response |
| rsp_err | input | 1 | Access failed |
| rsp_rdata | input | 8*BLK | Read data, byte i in lane i |
| busy | output | 1 | Command in progress |
| res_valid | output | 1 | Result pulse |
| res_dst | output | 64 | Updated destination |
| res_src | output | 64 | Updated source |
| res_cnt | output | 64 | Updated count |
| res_nzcv | output | 4 | Resulting flags |
| res_illegal | output | 1 | Command rejected |
| res_fault | output | 1 | Copy stopped on error |
| res_fault_addr | output | 64 | Failing address |
| res_fault_write | output | 1 | Failing access was a write |

## Verification
The bench checks that main and epilogue take the scheme from the incoming carry and not from the configuration input. A design that got this wrong would walk the wrong addresses and return counts of the wrong sign. It checks that a negative prologue count is clamped and that stage quotas truncate the copy. A design that mishandled either would copy too much or return a nonzero remainder where none is due. Fault runs put the error on a later write and on a first read. An engine that updated registers before the write completed, or reported the wrong direction, would return counts that do not match the bytes actually written. Odd-length and zero-length copies test block clipping and the untouched byte after the range.

// File: rtl/fwd_copy_engine.sv
module fwd_copy_engine #(
  parameter int BLK = 8,
  parameter int STAGE_QUOTA = 64,
  parameter logic [63:0] MAX_COPY = 64'd4096,
  localparam int LW = $clog2(BLK+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_scheme_b,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_stage,
  input  logic [1:0]       cmd_size,
  input  logic [3:0]       cmd_opts,
  input  logic [3:0]       cmd_nzcv,
  input  logic [63:0]      cmd_dst,
  input  logic [63:0]      cmd_src,
  input  logic [63:0]      cmd_cnt,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [63:0]      req_addr,
  output logic [LW-1:0]    req_len,
  output logic [8*BLK-1:0] req_wdata,
  output logic             req_nontemporal,
  output logic             req_unpriv,
  input  logic             rsp_valid,
  input  logic             rsp_err,
  input  logic [8*BLK-1:0] rsp_rdata,
  output logic             busy,
  output logic             res_valid,
  output logic [63:0]      res_dst,
  output logic [63:0]      res_src,
  output logic [63:0]      res_cnt,
  output logic [3:0]       res_nzcv,
  output logic             res_illegal,
  output logic             res_fault,
  output logic [63:0]      res_fault_addr,
  output logic             res_fault_write
);
  localparam logic [63:0] BLK64 = 64'(BLK);
  localparam logic [63:0] QUOTA64 = 64'(STAGE_QUOTA);

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RD, S_RDW, S_WR, S_WRW, S_DONE} st_t;
  st_t st;

  logic [63:0] dst, src, cnt, left;
  logic [3:0]  nzcv, opts;
  logic        sch_a, illegal, fault, fwr;
  logic [63:0] faddr;
  logic [LW-1:0] blen;
  logic [8*BLK-1:0] buf_q;

  logic        bad, prol, a_in;
  logic [63:0] psz, mag, quota_mag;
  assign bad  = (cmd_stage == 2'b11) || (cmd_size != 2'b00);
  assign prol = (cmd_stage == 2'b00);
  assign psz  = cmd_cnt[63] ? MAX_COPY : cmd_cnt;
  assign a_in = prol ? !cfg_scheme_b : !cmd_nzcv[1];
  always_comb begin
    if (prol) mag = psz;
    else      mag = a_in ? (64'd0 - cmd_cnt) : cmd_cnt;
    if (mag[63]) mag = 64'd0;
    quota_mag = (cmd_stage != 2'b10 && mag > QUOTA64) ? QUOTA64 : mag;
  end

  logic [63:0] rd_addr, wr_addr;
  assign rd_addr = sch_a ? src + cnt : src;
  assign wr_addr = sch_a ? dst + cnt : dst;

  assign busy      = (st != S_IDLE);
  assign cmd_ready = !busy;
  assign req_valid = (st == S_RD) || (st == S_WR);
  assign req_write = (st == S_WR);
  assign req_addr  = req_write ? wr_addr : rd_addr;
  assign req_len   = blen;
  assign req_wdata = buf_q;
  assign req_nontemporal = req_write ? opts[2] : opts[3];
  assign req_unpriv      = req_write ? opts[0] : opts[1];

  assign res_valid       = (st == S_DONE);
  assign res_dst         = dst;
  assign res_src         = src;
  assign res_cnt         = cnt;
  assign res_nzcv        = nzcv;
  assign res_illegal     = illegal;
  assign res_fault       = fault;
  assign res_fault_addr  = faddr;
  assign res_fault_write = fwr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dst <= '0; src <= '0; cnt <= '0; left <= '0;
      nzcv <= '0; opts <= '0; sch_a <= 1'b0;
      illegal <= 1'b0; fault <= 1'b0; fwr <= 1'b0; faddr <= '0;
      blen <= '0; buf_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          illegal <= bad;
          fault   <= 1'b0;
          fwr     <= 1'b0;
          faddr   <= '0;
          opts    <= cmd_opts;
          sch_a   <= a_in;
          left    <= quota_mag;
          if (bad || !prol) begin
            dst <= cmd_dst; src <= cmd_src; cnt <= cmd_cnt; nzcv <= cmd_nzcv;
          end else if (a_in) begin
            dst <= cmd_dst + psz; src <= cmd_src + psz;
            cnt <= 64'd0 - psz; nzcv <= 4'b0000;
          end else begin
            dst <= cmd_dst; src <= cmd_src; cnt <= psz; nzcv <= 4'b0010;
          end
          st <= bad ? S_DONE : S_CHK;
        end
        S_CHK: begin
          blen <= (left < BLK64) ? left[LW-1:0] : LW'(BLK);
          st   <= (left == 64'd0) ? S_DONE : S_RD;
        end
        S_RD: if (req_ready) st <= S_RDW;
        S_RDW: if (rsp_valid) begin
          if (rsp_err) begin
            fault <= 1'b1; faddr <= rd_addr; fwr <= 1'b0; st <= S_DONE;
          end else begin
            buf_q <= rsp_rdata; st <= S_WR;
          end
        end
        S_WR: if (req_ready) st <= S_WRW;
        S_WRW: if (rsp_valid) begin
          if (rsp_err) begin
            fault <= 1'b1; faddr <= wr_addr; fwr <= 1'b1; st <= S_DONE;
          end else begin
            if (sch_a) cnt <= cnt + 64'(blen);
            else begin
              dst <= dst + 64'(blen); src <= src + 64'(blen); cnt <= cnt - 64'(blen);
            end
            left <= left - 64'(blen);
            st   <= S_CHK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module fwd_copy_engine_chk #(
  parameter int BLK = 8,
  localparam int LW = $clog2(BLK+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cmd_ready,
  input logic          res_valid,
  input logic          res_illegal,
  input logic          res_fault,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [63:0]   req_addr,
  input logic [LW-1:0] req_len
);
  AST_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);  // R11
  AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);  // R11
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy && !res_valid);  // R11
  AST_REQ_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (int'(req_len) <= BLK));  // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write));  // R7
  AST_ILLEGAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_illegal |-> !res_fault);  // R1
endmodule

bind fwd_copy_engine fwd_copy_engine_chk #(.BLK(BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_ready(cmd_ready),
  .res_valid(res_valid), .res_illegal(res_illegal), .res_fault(res_fault),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_len(req_len)
);

// File: tb/fwd_copy_engine_tb.sv
`timescale 1ns/1ps
module fwd_copy_engine_tb;
  localparam int BLK = 8;
  localparam int QUOTA = 16;
  localparam logic [63:0] MAXC = 64'd40;
  localparam int LW = $clog2(BLK+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_scheme_b = 0, cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_stage = 0, cmd_size = 0;
  logic [3:0] cmd_opts = 0, cmd_nzcv = 0;
  logic [63:0] cmd_dst = 0, cmd_src = 0, cmd_cnt = 0;
  logic req_valid, req_write, req_nontemporal, req_unpriv;
  logic req_ready = 1'b1;
  logic [63:0] req_addr;
  logic [LW-1:0] req_len;
  logic [8*BLK-1:0] req_wdata, rsp_rdata;
  logic rsp_valid, rsp_err;
  logic busy, res_valid, res_illegal, res_fault, res_fault_write;
  logic [63:0] res_dst, res_src, res_cnt, res_fault_addr;
  logic [3:0] res_nzcv;

  fwd_copy_engine #(.BLK(BLK), .STAGE_QUOTA(QUOTA), .MAX_COPY(MAXC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_scheme_b(cfg_scheme_b),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_stage(cmd_stage),
    .cmd_size(cmd_size), .cmd_opts(cmd_opts), .cmd_nzcv(cmd_nzcv),
    .cmd_dst(cmd_dst), .cmd_src(cmd_src), .cmd_cnt(cmd_cnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_nontemporal(req_nontemporal), .req_unpriv(req_unpriv),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .busy(busy), .res_valid(res_valid), .res_dst(res_dst), .res_src(res_src),
    .res_cnt(res_cnt), .res_nzcv(res_nzcv), .res_illegal(res_illegal),
    .res_fault(res_fault), .res_fault_addr(res_fault_addr),
    .res_fault_write(res_fault_write));

  function automatic logic [7:0] pat(int i);
    return 8'(i) ^ 8'hA5 ^ 8'(i >> 8);
  endfunction

  logic [7:0] mem [1024];
  logic       flt_en = 0;
  logic [63:0] flt_at = 0;
  int         nreq;
  logic [1:0] rd_attr, wr_attr;

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    rsp_err   <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
      nreq <= 0;
      rsp_rdata <= '0;
    end else if (req_valid && req_ready) begin
      logic [8*BLK-1:0] rd;
      logic err;
      rd = '0;
      err = flt_en && (req_addr == flt_at);
      nreq <= nreq + 1;
      if (req_write) wr_attr <= {req_nontemporal, req_unpriv};
      else           rd_attr <= {req_nontemporal, req_unpriv};
      for (int i = 0; i < BLK; i++) begin
        logic [9:0] a;
        a = req_addr[9:0] + 10'(i);
        if (i < int'(req_len)) begin
          if (!req_write) rd[i*8 +: 8] = mem[a];
          else if (!err) mem[a] <= req_wdata[i*8 +: 8];
        end
      end
      rsp_rdata <= rd;
      rsp_err   <= err;
      rsp_valid <= 1'b1;
    end
  end

  int checks = 0, failures = 0;
  bit saw_busy;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] stg, input logic [1:0] sz, input logic [3:0] op,
                     input logic cb, input logic [3:0] nz,
                     input logic [63:0] d, input logic [63:0] s, input logic [63:0] c);
    @(negedge clk);
    cmd_stage = stg; cmd_size = sz; cmd_opts = op; cfg_scheme_b = cb;
    cmd_nzcv = nz; cmd_dst = d; cmd_src = s; cmd_cnt = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    saw_busy = busy;
    for (int k = 0; k < 500 && !res_valid; k++) begin
      @(negedge clk);
      if (busy) saw_busy = 1'b1;
    end
    chk(res_valid, "R11 result timeout", 64'(res_valid), 64'd1);
  endtask

  typedef struct packed {
    logic [1:0] stg; logic cb; logic [3:0] nz;
    logic [63:0] d, s, c, ed, es, ec; logic [3:0] enz;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 4'b0000, 64'h200, 64'h100, 64'd20, 64'h210, 64'h110, 64'd4, 4'b0010},
    '{2'b10, 1'b0, 4'b0010, 64'h210, 64'h110, 64'd4, 64'h214, 64'h114, 64'd0, 4'b0010},
    '{2'b00, 1'b0, 4'b1111, 64'h300, 64'h100, 64'd20, 64'h314, 64'h114, 64'hFFFF_FFFF_FFFF_FFFC, 4'b0000},
    '{2'b10, 1'b1, 4'b0000, 64'h314, 64'h114, 64'hFFFF_FFFF_FFFF_FFFC, 64'h314, 64'h114, 64'd0, 4'b0000},
    '{2'b01, 1'b0, 4'b0110, 64'h240, 64'h140, 64'd40, 64'h250, 64'h150, 64'd24, 4'b0110},
    '{2'b00, 1'b1, 4'b1000, 64'h280, 64'h180, 64'hFFFF_FFFF_FFFF_FFFF, 64'h290, 64'h190, 64'd24, 4'b0010},
    '{2'b00, 1'b0, 4'b0101, 64'h050, 64'h060, 64'd0, 64'h050, 64'h060, 64'd0, 4'b0000},
    '{2'b00, 1'b1, 4'b0000, 64'h2A0, 64'h1A3, 64'd5, 64'h2A5, 64'h1A8, 64'd0, 4'b0010}
  };

  initial begin : wdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !res_valid && !req_valid && cmd_ready, "R11 reset state",
        {60'd0, busy, res_valid, req_valid, cmd_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      run(t.stg, 2'b00, 4'b0000, t.cb, t.nz, t.d, t.s, t.c);
      chk(res_dst == t.ed, $sformatf("R3/R4/R6 vec%0d dst", v), res_dst, t.ed);
      chk(res_src == t.es, $sformatf("R3/R4 vec%0d src", v), res_src, t.es);
      chk(res_cnt == t.ec, $sformatf("R2/R6 vec%0d cnt", v), res_cnt, t.ec);
      chk(res_nzcv == t.enz, $sformatf("R5 vec%0d flags", v), 64'(res_nzcv), 64'(t.enz));
      chk(!res_fault && !res_illegal, $sformatf("R9 vec%0d no fault", v), 64'(res_fault), 64'd0);
    end
    chk(saw_busy, "R11 busy seen during copy", 64'(saw_busy), 64'd1);

    // R8 data content
    for (int i = 0; i < 20; i++)
      chk(mem[10'h200 + 10'(i)] == pat(10'h100 + i), "R8 scheme B data", 64'(mem[10'h200 + 10'(i)]), 64'(pat(10'h100 + i)));
    for (int i = 0; i < 20; i++)
      chk(mem[10'h300 + 10'(i)] == pat(10'h100 + i), "R8 scheme A data", 64'(mem[10'h300 + 10'(i)]), 64'(pat(10'h100 + i)));
    chk(mem[10'h214] == pat(10'h214), "R8 byte after range", 64'(mem[10'h214]), 64'(pat(10'h214)));
    chk(mem[10'h2A4] == pat(10'h1A7), "R7 clipped block last byte", 64'(mem[10'h2A4]), 64'(pat(10'h1A7)));
    chk(mem[10'h2A5] == pat(10'h2A5), "R7 clipped block no overrun", 64'(mem[10'h2A5]), 64'(pat(10'h2A5)));
    chk(mem[10'h250] == pat(10'h250), "R6 main quota stops", 64'(mem[10'h250]), 64'(pat(10'h250)));

    // R1 illegal stage and size
    n0 = nreq;
    run(2'b11, 2'b00, 4'b0000, 1'b0, 4'b1001, 64'h123, 64'h456, 64'd8);
    chk(res_illegal, "R1 stage 11 rejected", 64'(res_illegal), 64'd1);
    chk(res_dst == 64'h123 && res_cnt == 64'd8, "R1 regs echoed", res_dst, 64'h123);
    chk(res_nzcv == 4'b1001, "R1 flags echoed", 64'(res_nzcv), 64'h9);
    chk(nreq == n0, "R1 no memory access", 64'(nreq), 64'(n0));
    run(2'b00, 2'b01, 4'b0000, 1'b0, 4'b0111, 64'h123, 64'h456, 64'd8);
    chk(res_illegal && res_nzcv == 4'b0111, "R1 size 01 rejected", 64'(res_nzcv), 64'h7);
    chk(nreq == n0, "R1 size no memory access", 64'(nreq), 64'(n0));

    // R9 write fault in scheme B, R10 attributes
    flt_en = 1'b1; flt_at = 64'h3C8;
    run(2'b00, 2'b00, 4'b1011, 1'b1, 4'b0000, 64'h3C0, 64'h1C0, 64'd16);
    chk(res_fault && res_fault_write, "R9 write fault flagged", {62'd0, res_fault, res_fault_write}, 64'd3);
    chk(res_fault_addr == 64'h3C8, "R9 write fault addr", res_fault_addr, 64'h3C8);
    chk(res_dst == 64'h3C8 && res_src == 64'h1C8, "R9 partial addrs", res_dst, 64'h3C8);
    chk(res_cnt == 64'd8, "R9 partial count", res_cnt, 64'd8);
    chk(res_nzcv == 4'b0010, "R9 prologue flags on fault", 64'(res_nzcv), 64'h2);
    chk(mem[10'h3C8] == pat(10'h3C8), "R9 faulted block not written", 64'(mem[10'h3C8]), 64'(pat(10'h3C8)));
    chk(rd_attr == 2'b11, "R10 read attributes", 64'(rd_attr), 64'd3);
    chk(wr_attr == 2'b01, "R10 write attributes", 64'(wr_attr), 64'd1);

    // R9 read fault on first block, scheme A
    flt_at = 64'h1E0;
    run(2'b00, 2'b00, 4'b0100, 1'b0, 4'b1111, 64'h380, 64'h1E0, 64'd8);
    chk(res_fault && !res_fault_write, "R9 read fault direction", 64'(res_fault_write), 64'd0);
    chk(res_fault_addr == 64'h1E0, "R9 read fault addr", res_fault_addr, 64'h1E0);
    chk(res_dst == 64'h388 && res_src == 64'h1E8, "R3 offset kept on fault", res_dst, 64'h388);
    chk(res_cnt == 64'hFFFF_FFFF_FFFF_FFF8, "R3 negated count on fault", res_cnt, 64'hFFFF_FFFF_FFFF_FFF8);
    chk(res_nzcv == 4'b0000, "R3 flags cleared", 64'(res_nzcv), 64'd0);
    flt_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule